// File: doc/BRIEF.md
# Two-Way Write-Back Cache Controller

This block sits between a processor's load/store port and a word-wide memory port. It holds a small two-way set-associative cache of one-word lines. Each way keeps a valid flag, a dirty flag and a tag per set, and each set keeps one recency bit. A request is accepted from idle and resolved in a compare cycle. There, both tags of the indexed set are matched at once, and the matching way steers the read data.

A store that hits changes only the cached copy and marks it dirty, so memory goes stale. A miss picks a victim way. If the victim holds dirty data, that data is first written out to memory. The missing word is then read in and installed clean, and the request is compared again. A store miss therefore allocates the line and merges its data after the fill. Each access costs zero, one or two memory transactions.

The processor is stalled whenever a memory transaction is in flight. It holds its request until `cpu_ready` pulses.

Top module: `wb2way_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` and `mem_req` are low, and the first access to any address misses.
- R2: A load that hits returns the cached word with `cpu_ready` high in the cycle after the request is taken, with no memory transaction.
- R3: A store that hits updates only the cached word and marks it dirty; memory keeps its old value and a later load returns the new word.
- R4: A miss whose victim is clean or invalid makes exactly one memory read, at the word address of the request with byte-offset bits zero. The filled word is then returned, with `cpu_ready` in the cycle after the read is acknowledged.
- R5: A store miss reads the line from memory first and then writes the whole store word into it (byte-offset bits of the address are ignored), leaving it dirty.
- R6: A miss whose victim is valid and dirty first writes the victim word to memory (`mem_we`=1) at the victim's own address, then reads the requested word (`mem_we`=0): two transactions.
- R7: When both ways are valid, the victim is the way not referenced most recently in that set; every hit or completed miss marks its way as most recent.
- R8: A miss in a set that still has an invalid way fills that way and writes nothing back, even when the other way is dirty.
- R9: Address bits [1:0] are byte offset, the next log2(SETS) bits select the set, and the upper bits are the tag. Two addresses in one set with different tags can reside together, so alternating between them misses only twice.
- R10: While a memory transaction is open, `cpu_ready` stays low, and `mem_req`, `mem_we` and `mem_addr` hold until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write-back, 0 = fill read |
| mem_addr | output | ADDR_W | Word-aligned memory byte address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_rdata | input | DATA_W | Fill data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes the transaction this cycle |

## Verification
The bench drives a sequence of loads and stores that lands in the four cases that matter: hit, clean-victim miss, dirty-victim miss, and miss into a set with a free way. It counts memory reads and writes per access, which separates the zero-, one- and two-transaction paths. A store-then-evict sequence shows whether store data merged after a fill actually reaches memory, and whether a hit left memory stale. Reuse of one way before a conflicting miss tells recency-based victim choice apart from a fixed or stale choice. An alternating two-tag string in one set tells true two-way residency from direct-mapped thrashing.

// File: rtl/wb2c_pkg.sv
package wb2c_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CMP  = 2'd1,
      ST_WB   = 2'd2,
      ST_FILL = 2'd3
   } wb2c_state_e;
endpackage

// File: rtl/wb2c_match.sv
module wb2c_match #(
   parameter int TAG_W = 28,
   parameter int WAYS  = 2
) (
   input  logic [WAYS-1:0]            way_vld,
   input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
   input  logic [TAG_W-1:0]           req_tag,
   output logic                       hit,
   output logic [$clog2(WAYS)-1:0]    hit_way
);
   logic [WAYS-1:0] match;

   // one comparator per way, all working in parallel
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = way_vld[w] && (way_tag[w] == req_tag);
   end

   always_comb begin
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--)
         if (match[w]) hit_way = w[$clog2(WAYS)-1:0];
   end

   assign hit = |match;
endmodule

// File: rtl/wb2c_array.sv
module wb2c_array #(
   parameter int SETS   = 4,
   parameter int TAG_W  = 28,
   parameter int DATA_W = 32,
   parameter int WAYS   = 2,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [IDX_W-1:0]            idx,
   output logic [WAYS-1:0]             set_vld,
   output logic [WAYS-1:0]             set_dirty,
   output logic [WAYS-1:0][TAG_W-1:0]  set_tag,
   output logic [WAYS-1:0][DATA_W-1:0] set_data,
   output logic [WAY_W-1:0]            set_lru,
   input  logic                        fill_en,
   input  logic [WAY_W-1:0]            fill_way,
   input  logic [TAG_W-1:0]            fill_tag,
   input  logic [DATA_W-1:0]           fill_data,
   input  logic                        st_en,
   input  logic [WAY_W-1:0]            acc_way,
   input  logic [DATA_W-1:0]           st_data,
   input  logic                        touch_en
);
   logic [WAYS-1:0]             vld_q   [SETS];
   logic [WAYS-1:0]             dirty_q [SETS];
   logic [WAY_W-1:0]            lru_q   [SETS];
   logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
   logic [WAYS-1:0][DATA_W-1:0] data_q  [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s]   <= '0;
            dirty_q[s] <= '0;
            lru_q[s]   <= '0;
         end
      end else begin
         if (fill_en) begin
            vld_q[idx][fill_way]   <= 1'b1;
            dirty_q[idx][fill_way] <= 1'b0;
         end
         if (st_en) dirty_q[idx][acc_way] <= 1'b1;
         // the recency bit names the way to evict next
         if (touch_en) lru_q[idx] <= ~acc_way;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_q[idx][fill_way]  <= fill_tag;
         data_q[idx][fill_way] <= fill_data;
      end
      if (st_en) data_q[idx][acc_way] <= st_data;
   end

   assign set_vld   = vld_q[idx];
   assign set_dirty = dirty_q[idx];
   assign set_tag   = tag_q[idx];
   assign set_data  = data_q[idx];
   assign set_lru   = lru_q[idx];
endmodule

// File: rtl/wb2c_ctrl.sv
module wb2c_ctrl
   import wb2c_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cpu_req,
   input  logic        cpu_we,
   input  logic        hit,
   input  logic [1:0]  set_vld,
   input  logic [1:0]  set_dirty,
   input  logic        set_lru,
   input  logic        mem_ack,
   output wb2c_state_e state,
   output logic        vic_q,
   output logic        cpu_ready,
   output logic        fill_en,
   output logic        st_en,
   output logic        mem_req,
   output logic        mem_we
);
   logic victim;

   // free way first (way 0 before way 1), recency bit otherwise
   always_comb begin
      if (!set_vld[0])      victim = 1'b0;
      else if (!set_vld[1]) victim = 1'b1;
      else                  victim = set_lru;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         vic_q <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (cpu_req) state <= ST_CMP;
            ST_CMP: begin
               if (hit) state <= ST_IDLE;
               else begin
                  vic_q <= victim;
                  state <= (set_vld[victim] && set_dirty[victim]) ? ST_WB : ST_FILL;
               end
            end
            ST_WB:   if (mem_ack) state <= ST_FILL;
            ST_FILL: if (mem_ack) state <= ST_CMP;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cpu_ready = (state == ST_CMP) && hit;
   assign st_en     = cpu_ready && cpu_we;
   assign fill_en   = (state == ST_FILL) && mem_ack;
   assign mem_req   = (state == ST_WB) || (state == ST_FILL);
   assign mem_we    = (state == ST_WB);
endmodule

// File: rtl/wb2way_cache.sv
module wb2way_cache
   import wb2c_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int SETS   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   localparam int WAYS  = 2;
   localparam int OFF_W = $clog2(DATA_W / 8);
   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("DATA_W must be a power-of-two number of bits, at least 8");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too narrow for SETS and DATA_W");
   end

   logic [IDX_W-1:0]            idx;
   logic [TAG_W-1:0]            req_tag;
   logic [OFF_W-1:0]            addr_off_unused;
   logic [WAYS-1:0]             set_vld, set_dirty;
   logic [WAYS-1:0][TAG_W-1:0]  set_tag;
   logic [WAYS-1:0][DATA_W-1:0] set_data;
   logic                        set_lru, hit, hit_way, vic_q;
   logic                        fill_en, st_en;
   wb2c_state_e                 state;

   assign addr_off_unused = cpu_addr[OFF_W-1:0];
   assign idx     = cpu_addr[OFF_W +: IDX_W];
   assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];

   wb2c_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_match (
      .way_vld (set_vld),
      .way_tag (set_tag),
      .req_tag (req_tag),
      .hit     (hit),
      .hit_way (hit_way)
   );

   wb2c_array #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W), .WAYS(WAYS)) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx       (idx),
      .set_vld   (set_vld),
      .set_dirty (set_dirty),
      .set_tag   (set_tag),
      .set_data  (set_data),
      .set_lru   (set_lru),
      .fill_en   (fill_en),
      .fill_way  (vic_q),
      .fill_tag  (req_tag),
      .fill_data (mem_rdata),
      .st_en     (st_en),
      .acc_way   (hit_way),
      .st_data   (cpu_wdata),
      .touch_en  (cpu_ready)
   );

   wb2c_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_req   (cpu_req),
      .cpu_we    (cpu_we),
      .hit       (hit),
      .set_vld   (set_vld),
      .set_dirty (set_dirty),
      .set_lru   (set_lru),
      .mem_ack   (mem_ack),
      .state     (state),
      .vic_q     (vic_q),
      .cpu_ready (cpu_ready),
      .fill_en   (fill_en),
      .st_en     (st_en),
      .mem_req   (mem_req),
      .mem_we    (mem_we)
   );

   assign cpu_rdata = set_data[hit_way];
   assign mem_wdata = set_data[vic_q];
   assign mem_addr  = mem_we ? {set_tag[vic_q], idx, {OFF_W{1'b0}}}
                             : {req_tag, idx, {OFF_W{1'b0}}};
endmodule

// File: rtl/wb2way_cache_chk.sv
module wb2way_cache_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ack
);
   always @(posedge clk)
      if (!rst_n) p_rst_quiet_r1: assert (!mem_req && !cpu_ready);

   p_hit_has_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_req);

   p_fill_then_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we && mem_ack |=> cpu_ready);

   p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_ack |=> mem_req && !mem_we);

   p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !mem_req);

   p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr));
endmodule

bind wb2way_cache wb2way_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_ready (cpu_ready),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_ack   (mem_ack)
);

// File: tb/wb2way_cache_bench.sv
module wb2way_cache_bench;
   localparam int CLK_PERIOD = 10;
   localparam int MEM_LAT    = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_ready, mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;

   int tests = 0, fails = 0;
   int rd_cnt = 0, wr_cnt = 0, lat = 0;
   logic [31:0] last_wa = '0, last_wd = '0, last_ra = '0;
   logic [31:0] mem_model [256];

   typedef struct { bit chk; logic [31:0] d; string r; } exp_t;
   exp_t sb [$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   wb2way_cache u_wb2way_cache (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack)
   );

   task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   // memory model: answers MEM_LAT cycles after a request, at falling edges
   always @(negedge clk) begin
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
         if (lat == MEM_LAT) begin
            lat = 0;
            mem_ack = 1'b1;
            if (mem_we) begin
               mem_model[mem_addr[9:2]] = mem_wdata;
               wr_cnt++; last_wa = mem_addr; last_wd = mem_wdata;
            end else begin
               mem_rdata = mem_model[mem_addr[9:2]];
               rd_cnt++; last_ra = mem_addr;
            end
         end else lat++;
      end
   end

   // monitor: pops the scoreboard as each access completes
   always @(negedge clk) begin
      if (rst_n && cpu_req && cpu_ready) begin
         if (sb.size() == 0) check(1'b0, "scoreboard underflow", cpu_rdata, '0);
         else begin
            exp_t e = sb.pop_front();
            if (e.chk) check(cpu_rdata == e.d, e.r, cpu_rdata, e.d);
         end
      end
   end

   task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                         input bit chk_d, input logic [31:0] exp_d,
                         input int exp_rd, input int exp_wr, input string r);
      int rd0 = rd_cnt, wr0 = wr_cnt, waits = 0;
      exp_t e;
      e.chk = chk_d; e.d = exp_d; e.r = r;
      sb.push_back(e);
      cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_req = 1'b1;
      do begin
         @(negedge clk);
         waits++;
      end while (!cpu_ready && waits < 100);
      @(negedge clk);
      cpu_req = 1'b0;
      check(rd_cnt - rd0 == exp_rd, {r, " memory reads"}, rd_cnt - rd0, exp_rd);
      check(wr_cnt - wr0 == exp_wr, {r, " memory writes"}, wr_cnt - wr0, exp_wr);
      if (exp_rd + exp_wr == 0)
         check(waits == 1, {r, " hit latency"}, waits, 1);
      else
         check(waits > 1, {r, " R10 stall on miss"}, waits, 2);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++; tests++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem_model[i] = 32'hC0DE_0000 + i;
      repeat (3) @(negedge clk);
      check(!cpu_ready, "R1 ready low in reset", cpu_ready, 0);
      check(!mem_req, "R1 mem_req low in reset", mem_req, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!cpu_ready && !mem_req, "R1 quiet after reset", {cpu_ready, mem_req}, 0);

      // set 0: 0x000, 0x010, 0x020 differ only in tag
      access(0, 32'h000, 0, 1, 32'hC0DE_0000, 1, 0, "R1 R4 first load misses");
      check(last_ra == 32'h000, "R4 fill address", last_ra, 32'h000);
      access(0, 32'h000, 0, 1, 32'hC0DE_0000, 0, 0, "R2 load hit");
      access(1, 32'h013, 32'h1111_2222, 0, 0, 1, 0, "R5 R8 store miss into free way");
      check(last_ra == 32'h010, "R5 R9 fill address with offset cleared", last_ra, 32'h010);
      access(1, 32'h010, 32'h3333_4444, 0, 0, 0, 0, "R3 store hit");
      check(mem_model[4] == 32'hC0DE_0004, "R3 memory left stale", mem_model[4], 32'hC0DE_0004);
      access(0, 32'h010, 0, 1, 32'h3333_4444, 0, 0, "R3 load after store hit");
      access(0, 32'h000, 0, 1, 32'hC0DE_0000, 0, 0, "R7 touch 0x000");
      access(0, 32'h020, 0, 1, 32'hC0DE_0008, 1, 1, "R6 R7 dirty victim evicted");
      check(last_wa == 32'h010, "R6 write-back address", last_wa, 32'h010);
      check(last_wd == 32'h3333_4444, "R6 write-back data", last_wd, 32'h3333_4444);
      access(0, 32'h000, 0, 1, 32'hC0DE_0000, 0, 0, "R7 recent line survived");
      access(0, 32'h010, 0, 1, 32'h3333_4444, 1, 0, "R4 R7 clean victim refetch");

      // set 1: alternating two tags
      for (int k = 0; k < 4; k++) begin
         access(0, 32'h044, 0, 1, 32'hC0DE_0011, k == 0 ? 1 : 0, 0, "R9 alternate A");
         access(0, 32'h084, 0, 1, 32'hC0DE_0021, k == 0 ? 1 : 0, 0, "R9 alternate B");
      end

      // set 2: second store miss must not write back the dirty first way
      access(1, 32'h008, 32'hAAAA_0001, 0, 0, 1, 0, "R5 store miss set 2");
      access(1, 32'h018, 32'hBBBB_0002, 0, 0, 1, 0, "R8 free way preferred over dirty");
      access(0, 32'h028, 0, 1, 32'hC0DE_000A, 1, 1, "R6 R7 LRU dirty evicted");
      check(last_wa == 32'h008 && last_wd == 32'hAAAA_0001, "R5 R7 merged store written back",
            last_wd, 32'hAAAA_0001);
      access(0, 32'h018, 0, 1, 32'hBBBB_0002, 0, 0, "R7 other way kept");

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule